// File: doc/BRIEF.md
# Stereo Audio Sample FIFO and Interrupt Front-End

This block sits between a processor bus and a stereo serial audio serializer. Software programs it through a small word-addressed register set. Each access to the data port carries one 32-bit word, a packed left/right pair of 16-bit samples. A write to the data port queues a word for playback. A read takes the oldest captured word. Two 16-entry FIFOs decouple the bus from the serializer. The serializer side is a plain handshake. The serializer pulls playback words with a ready strobe and offers capture words with a valid strobe.

Each FIFO has its own 4-bit trigger threshold. When a FIFO level crosses its threshold, the block raises a service request, and that request drives both a DMA request line and an interrupt source. Playback starvation and capture overflow each set a sticky flag, which software clears by writing one. A single interrupt output ORs every status condition whose mask bit is set. A control bit holds both FIFOs and the sticky flags in reset. A loopback mode routes played words straight back into the capture FIFO.

Top module: `audfe_top`

## Requirements
- R1: Address map (word address on `bus_addr_i`): 0 control, 1 format, 2 status, 3 interrupt mask, 4 interrupt clear, 5 data port; other addresses read 0. `bus_rdata_o` is combinational and is 0 unless a read (`bus_sel_i`=1, `bus_we_i`=0) is in progress. After reset, control, format and mask read 0, both FIFOs are empty and status reads 0x81.
- R2: Control layout: bit 0 link enable (`link_en_o`), bit 2 bit-clock drive (`bclk_drive_o`), bit 3 FIFO/flag reset, bits 11:8 transmit threshold, bits 15:12 receive threshold. Only these bits are stored and read back.
- R3: Format layout: bit 0 MSB-justified select (`msb_just_o`), bit 3 capture disable, bit 4 playback disable, bit 5 loopback; only these bits are stored. With playback disabled, `tx_ready_i` pops nothing and flags no underrun. With capture disabled, captured words are ignored.
- R4: A data-port write pushes the whole 32-bit word into the 16-entry transmit FIFO, whether or not the link is enabled. A write to a full FIFO with no concurrent pop is dropped. `tx_valid_o` = link active (enable set, reset bit clear) AND playback enabled AND FIFO not empty. `tx_data_o` is then the oldest word, and 0 otherwise. The word is popped on `tx_ready_i` while `tx_valid_o` is high.
- R5: `tx_ready_i` while the link is active, playback is enabled and the transmit FIFO is empty sets sticky underrun (status bit 5), and `tx_data_o` is 0 in that cycle.
- R6: `rx_valid_i` while the link is active, capture is enabled and loopback is off pushes `rx_data_i`. If the receive FIFO is full and no read pops that cycle, the word is dropped and sticky overrun (status bit 6) is set.
- R7: A data-port read returns the oldest receive word and pops it. A read of an empty receive FIFO returns 0 and changes nothing.
- R8: Writing 1 to clear-register bit 6 clears overrun, and writing 1 to bit 5 clears underrun. If a new event occurs in the same cycle as the clear, the flag stays set.
- R9: The transmit service request (status bit 3, `dma_tx_req_o`) is high when the link is active, playback is enabled and the transmit level is at or below the transmit threshold. The receive service request (status bit 4, `dma_rx_req_o`) is high when the link is active, capture is enabled and the receive level is at or above the receive threshold.
- R10: Mask register bits 6:3 enable the overrun, underrun, receive-service and transmit-service interrupts; only these bits are stored. `irq_o` is the OR over bits 6:3 of status AND mask.
- R11: While control bit 3 is set, both FIFOs are flushed at every clock edge and both sticky flags are cleared. Serializer transfers, data-port pushes and data-port pops have no effect.
- R12: With loopback on, every word popped by the serializer is pushed into the receive FIFO, and `rx_valid_i` is ignored.
- R13: Status bit 7 reads 1 when the enable bit is clear. Bit 2 (busy) reads 1 when the link is active and the transmit FIFO is not empty. Bit 1 reads 1 when the receive FIFO is not empty. Bit 0 reads 1 when the transmit FIFO is not full.
- R14: A push to a full FIFO in the same cycle as a pop from it is accepted, and the FIFO stays full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 3 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data (combinational) |
| tx_ready_i | input | 1 | Serializer requests a playback word |
| tx_valid_o | output | 1 | Playback word available |
| tx_data_o | output | 32 | Playback word (stereo pair) |
| rx_valid_i | input | 1 | Serializer offers a capture word |
| rx_data_i | input | 32 | Capture word (stereo pair) |
| link_en_o | output | 1 | Link enable to serializer |
| bclk_drive_o | output | 1 | Block drives the bit clock |
| msb_just_o | output | 1 | MSB-justified framing select |
| irq_o | output | 1 | Combined interrupt |
| dma_tx_req_o | output | 1 | Transmit DMA request |
| dma_rx_req_o | output | 1 | Receive DMA request |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a bus access and a serializer transfer on the same FIFO: a data-port write while `tx_ready_i` pops a full transmit FIFO, or a data-port read while `rx_valid_i` arrives at a full receive FIFO. The second pair is a flag-clear write and a fresh underrun. The bench provokes each pair by driving both strobes in one cycle against a FIFO that was first filled, or drained, to its limit. A queue-based reference model judges the next FIFO level, the data order and the sticky-flag value, and every port is compared with that model on every clock.

// File: rtl/audfe_pkg.sv
package audfe_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 3'd0,
    A_FMT  = 3'd1,
    A_STAT = 3'd2,
    A_MASK = 3'd3,
    A_CLR  = 3'd4,
    A_DATA = 3'd5
  } addr_e;

  localparam int unsigned THR_W = 4;

  // control bit positions
  localparam int unsigned C_EN    = 0;
  localparam int unsigned C_BCLK  = 2;
  localparam int unsigned C_RST   = 3;
  localparam int unsigned C_TXT   = 8;
  localparam int unsigned C_RXT   = 12;
  // format bit positions
  localparam int unsigned F_MSB   = 0;
  localparam int unsigned F_DREC  = 3;
  localparam int unsigned F_DPLAY = 4;
  localparam int unsigned F_LPBK  = 5;
  // status / mask / clear bit positions
  localparam int unsigned S_TNF   = 0;
  localparam int unsigned S_RNE   = 1;
  localparam int unsigned S_BSY   = 2;
  localparam int unsigned S_TSR   = 3;
  localparam int unsigned S_RSR   = 4;
  localparam int unsigned S_UDR   = 5;
  localparam int unsigned S_OVR   = 6;
  localparam int unsigned S_OFF   = 7;

  typedef struct packed {
    logic [THR_W-1:0] rx_thr;
    logic [THR_W-1:0] tx_thr;
    logic             rst;
    logic             bclk;
    logic             en;
  } ctrl_t;

  typedef struct packed {
    logic lpbk;
    logic dplay;
    logic drec;
    logic msb;
  } fmt_t;
endpackage

// File: rtl/audfe_fifo.sv
module audfe_fifo #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned LW   = PW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_req_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_req_i,
  output logic          push_ok_o,
  output logic          pop_ok_o,
  output logic [DW-1:0] head_o,
  output logic [LW-1:0] level_o,
  output logic          empty_o,
  output logic          full_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wptr_q, rptr_q;
  logic [LW-1:0] level_q;

  assign empty_o   = (level_q == '0);
  assign full_o    = (level_q == LW'(DEPTH));
  assign pop_ok_o  = pop_req_i & ~empty_o & ~flush_i;
  // a pop in the same cycle frees the slot
  assign push_ok_o = push_req_i & ~flush_i & (~full_o | pop_ok_o);
  assign head_o    = mem_q[rptr_q];
  assign level_o   = level_q;

  always_ff @(posedge clk_i) begin
    if (push_ok_o) mem_q[wptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      level_q <= '0;
    end else if (flush_i) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      level_q <= '0;
    end else begin
      if (push_ok_o) wptr_q <= wptr_q + 1'b1;
      if (pop_ok_o)  rptr_q <= rptr_q + 1'b1;
      unique case ({push_ok_o, pop_ok_o})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
    end
  end

  // R4
  lvl_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_q <= LW'(DEPTH));
  // R14
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_req_i && !flush_i) |=> full_o || $past(pop_ok_o) == 1'b0 && full_o || $past(pop_ok_o));
  // R11
  flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);
  // R7
  empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_req_i && !push_req_i) |=> empty_o);
endmodule

// File: rtl/audfe_regs.sv
module audfe_regs
  import audfe_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       wdata_i,
  input  logic              ovr_ev_i,
  input  logic              udr_ev_i,
  output ctrl_t             ctrl_o,
  output fmt_t              fmt_o,
  output logic [3:0]        mask_o,
  output logic              ovr_o,
  output logic              udr_o
);
  ctrl_t      ctrl_q;
  fmt_t       fmt_q;
  logic [3:0] mask_q;
  logic       ovr_q, udr_q;
  logic       clr_ovr, clr_udr;

  assign clr_ovr = wr_i && (addr_i == A_CLR) && wdata_i[S_OVR];
  assign clr_udr = wr_i && (addr_i == A_CLR) && wdata_i[S_UDR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      fmt_q  <= '0;
      mask_q <= '0;
    end else if (wr_i) begin
      unique case (addr_i)
        A_CTRL: ctrl_q <= '{rx_thr: wdata_i[C_RXT +: THR_W],
                            tx_thr: wdata_i[C_TXT +: THR_W],
                            rst:    wdata_i[C_RST],
                            bclk:   wdata_i[C_BCLK],
                            en:     wdata_i[C_EN]};
        A_FMT:  fmt_q  <= '{lpbk:  wdata_i[F_LPBK],
                            dplay: wdata_i[F_DPLAY],
                            drec:  wdata_i[F_DREC],
                            msb:   wdata_i[F_MSB]};
        A_MASK: mask_q <= wdata_i[S_OVR:S_TSR];
        default: ;
      endcase
    end
  end

  // new events win over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovr_q <= 1'b0;
      udr_q <= 1'b0;
    end else if (ctrl_q.rst) begin
      ovr_q <= 1'b0;
      udr_q <= 1'b0;
    end else begin
      ovr_q <= ovr_ev_i | (ovr_q & ~clr_ovr);
      udr_q <= udr_ev_i | (udr_q & ~clr_udr);
    end
  end

  assign ctrl_o = ctrl_q;
  assign fmt_o  = fmt_q;
  assign mask_o = mask_q;
  assign ovr_o  = ovr_q;
  assign udr_o  = udr_q;

  // R8
  ovr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_ev_i && !ctrl_q.rst) |=> ovr_o);
  // R8
  udr_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_udr && !udr_ev_i) |=> !udr_o);
  // R11
  flag_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.rst |=> !ovr_o && !udr_o);
endmodule

// File: rtl/audfe_status.sv
module audfe_status
  import audfe_pkg::*;
#(
  parameter int unsigned LW = 5,
  parameter int unsigned DEPTH = 16
) (
  input  ctrl_t         ctrl_i,
  input  fmt_t          fmt_i,
  input  logic [3:0]    mask_i,
  input  logic          ovr_i,
  input  logic          udr_i,
  input  logic [LW-1:0] tx_level_i,
  input  logic [LW-1:0] rx_level_i,
  output logic [7:0]    status_o,
  output logic          tx_svc_o,
  output logic          rx_svc_o,
  output logic          irq_o
);
  logic active;

  assign active   = ctrl_i.en & ~ctrl_i.rst;
  assign tx_svc_o = active & ~fmt_i.dplay & (tx_level_i <= LW'(ctrl_i.tx_thr));
  assign rx_svc_o = active & ~fmt_i.drec  & (rx_level_i >= LW'(ctrl_i.rx_thr));

  always_comb begin
    status_o        = '0;
    status_o[S_OFF] = ~ctrl_i.en;
    status_o[S_OVR] = ovr_i;
    status_o[S_UDR] = udr_i;
    status_o[S_RSR] = rx_svc_o;
    status_o[S_TSR] = tx_svc_o;
    status_o[S_BSY] = active & (tx_level_i != '0);
    status_o[S_RNE] = (rx_level_i != '0);
    status_o[S_TNF] = (tx_level_i != LW'(DEPTH));
  end

  assign irq_o = |(status_o[S_OVR:S_TSR] & mask_i);
endmodule

// File: rtl/audfe_top.sv
module audfe_top
  import audfe_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned LW   = $clog2(DEPTH) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DW-1:0]     bus_wdata_i,
  output logic [DW-1:0]     bus_rdata_o,
  input  logic              tx_ready_i,
  output logic              tx_valid_o,
  output logic [DW-1:0]     tx_data_o,
  input  logic              rx_valid_i,
  input  logic [DW-1:0]     rx_data_i,
  output logic              link_en_o,
  output logic              bclk_drive_o,
  output logic              msb_just_o,
  output logic              irq_o,
  output logic              dma_tx_req_o,
  output logic              dma_rx_req_o
);
  ctrl_t         ctrl;
  fmt_t          fmt;
  logic [3:0]    mask;
  logic          ovr, udr, ovr_ev, udr_ev;
  logic          active, tx_go, bus_wr, bus_rd, data_wr, data_rd;
  logic          tx_push_ok, tx_pop_ok, tx_empty, tx_full;
  logic          rx_push_ok, rx_pop_ok, rx_empty, rx_full;
  logic [DW-1:0] tx_head, rx_head, rx_src_d;
  logic [LW-1:0] tx_level, rx_level;
  logic          rx_src_v, rx_in;
  logic [7:0]    status;
  logic          tx_svc, rx_svc;

  assign bus_wr  = bus_sel_i & bus_we_i;
  assign bus_rd  = bus_sel_i & ~bus_we_i;
  assign data_wr = bus_wr & (bus_addr_i == A_DATA);
  assign data_rd = bus_rd & (bus_addr_i == A_DATA);

  assign active  = ctrl.en & ~ctrl.rst;
  assign tx_go   = active & ~fmt.dplay;

  audfe_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (bus_wr),
    .addr_i   (bus_addr_i),
    .wdata_i  (bus_wdata_i[15:0]),
    .ovr_ev_i (ovr_ev),
    .udr_ev_i (udr_ev),
    .ctrl_o   (ctrl),
    .fmt_o    (fmt),
    .mask_o   (mask),
    .ovr_o    (ovr),
    .udr_o    (udr)
  );

  audfe_fifo #(.DW(DW), .DEPTH(DEPTH)) u_tx_fifo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (ctrl.rst),
    .push_req_i (data_wr),
    .wdata_i    (bus_wdata_i),
    .pop_req_i  (tx_go & tx_ready_i),
    .push_ok_o  (tx_push_ok),
    .pop_ok_o   (tx_pop_ok),
    .head_o     (tx_head),
    .level_o    (tx_level),
    .empty_o    (tx_empty),
    .full_o     (tx_full)
  );

  assign udr_ev     = tx_go & tx_ready_i & tx_empty;
  assign tx_valid_o = tx_go & ~tx_empty;
  assign tx_data_o  = tx_valid_o ? tx_head : '0;

  // loopback feeds played words straight back to capture
  assign rx_src_v = fmt.lpbk ? tx_pop_ok : rx_valid_i;
  assign rx_src_d = fmt.lpbk ? tx_head   : rx_data_i;
  assign rx_in    = active & ~fmt.drec & rx_src_v;

  audfe_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rx_fifo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (ctrl.rst),
    .push_req_i (rx_in),
    .wdata_i    (rx_src_d),
    .pop_req_i  (data_rd),
    .push_ok_o  (rx_push_ok),
    .pop_ok_o   (rx_pop_ok),
    .head_o     (rx_head),
    .level_o    (rx_level),
    .empty_o    (rx_empty),
    .full_o     (rx_full)
  );

  assign ovr_ev = rx_in & ~rx_push_ok;

  audfe_status #(.LW(LW), .DEPTH(DEPTH)) u_status (
    .ctrl_i     (ctrl),
    .fmt_i      (fmt),
    .mask_i     (mask),
    .ovr_i      (ovr),
    .udr_i      (udr),
    .tx_level_i (tx_level),
    .rx_level_i (rx_level),
    .status_o   (status),
    .tx_svc_o   (tx_svc),
    .rx_svc_o   (rx_svc),
    .irq_o      (irq_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (bus_rd) begin
      unique case (bus_addr_i)
        A_CTRL: begin
          bus_rdata_o[C_EN]          = ctrl.en;
          bus_rdata_o[C_BCLK]        = ctrl.bclk;
          bus_rdata_o[C_RST]         = ctrl.rst;
          bus_rdata_o[C_TXT +: THR_W] = ctrl.tx_thr;
          bus_rdata_o[C_RXT +: THR_W] = ctrl.rx_thr;
        end
        A_FMT: begin
          bus_rdata_o[F_MSB]   = fmt.msb;
          bus_rdata_o[F_DREC]  = fmt.drec;
          bus_rdata_o[F_DPLAY] = fmt.dplay;
          bus_rdata_o[F_LPBK]  = fmt.lpbk;
        end
        A_STAT: bus_rdata_o[7:0] = status;
        A_MASK: bus_rdata_o[S_OVR:S_TSR] = mask;
        A_DATA: bus_rdata_o = rx_empty ? '0 : rx_head;
        default: ;
      endcase
    end
  end

  assign link_en_o    = ctrl.en;
  assign bclk_drive_o = ctrl.bclk;
  assign msb_just_o   = fmt.msb;
  assign dma_tx_req_o = tx_svc;
  assign dma_rx_req_o = rx_svc;

  // R5
  udr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_ready_i && !tx_valid_o) |-> tx_data_o == '0);
  // R9
  dma_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !link_en_o |-> !dma_tx_req_o && !dma_rx_req_o);
  // R11
  rst_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl.rst |=> (tx_level == '0) && (rx_level == '0));
  // R12
  lpbk_ign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fmt.lpbk && rx_valid_i && !tx_pop_ok && !data_rd && !ctrl.rst) |=> $stable(rx_level));
  // R6
  ovr_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_ev |-> rx_full && !rx_pop_ok);
  // R4
  push_lvl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_push_ok && !tx_pop_ok) |=> tx_level == $past(tx_level) + 1'b1);
  // R13
  tnf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_full |-> !status[S_TNF]);
endmodule

// File: tb/audfe_top_tb_top.sv
`timescale 1ns/1ps
module audfe_top_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_sel_i = 1'b0, bus_we_i = 1'b0;
  logic [2:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic        tx_ready_i = 1'b0, tx_valid_o;
  logic [31:0] tx_data_o;
  logic        rx_valid_i = 1'b0;
  logic [31:0] rx_data_i = '0;
  logic        link_en_o, bclk_drive_o, msb_just_o, irq_o, dma_tx_req_o, dma_rx_req_o;

  always #2.5 clk_i = ~clk_i;

  audfe_top dut_i (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model state
  logic [31:0] m_ctrl = 0, m_fmt = 0, m_mask = 0;
  bit          m_ovr = 0, m_udr = 0;
  logic [31:0] q_tx[$], q_rx[$];

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic cyc(bit s, bit w, logic [2:0] a, logic [31:0] d,
                     bit tr, bit rv, logic [31:0] rdd, string tag);
    bit en, rstb, act, dpl, drc, lp, tsvc, rsvc, txv, irq;
    bit tx_pop, udr_ev, tx_push, rx_v, rx_in, rx_pop, rx_push, ovr_ev;
    logic [31:0] rx_d, exp_rd, head;
    logic [7:0] st;
    int txl, rxl;
    @(negedge clk_i);
    bus_sel_i = s; bus_we_i = w; bus_addr_i = a; bus_wdata_i = d;
    tx_ready_i = tr; rx_valid_i = rv; rx_data_i = rdd;
    #1;
    en = m_ctrl[0]; rstb = m_ctrl[3]; act = en && !rstb;
    dpl = m_fmt[4]; drc = m_fmt[3]; lp = m_fmt[5];
    txl = q_tx.size(); rxl = q_rx.size();
    tsvc = act && !dpl && (txl <= int'(m_ctrl[11:8]));
    rsvc = act && !drc && (rxl >= int'(m_ctrl[15:12]));
    st = {!en, m_ovr, m_udr, rsvc, tsvc, act && txl > 0, rxl > 0, txl < 16};
    irq = |(st[6:3] & m_mask[6:3]);
    txv = act && !dpl && txl > 0;
    head = (txl > 0) ? q_tx[0] : 32'h0;
    exp_rd = 0;
    if (s && !w)
      case (a)
        0: exp_rd = m_ctrl;
        1: exp_rd = m_fmt;
        2: exp_rd = {24'h0, st};
        3: exp_rd = m_mask;
        5: exp_rd = (rxl > 0) ? q_rx[0] : 32'h0;
        default: exp_rd = 0;
      endcase
    chk(tag, "rdata", bus_rdata_o, exp_rd);
    chk("R4", "tx_valid", {31'h0, tx_valid_o}, {31'h0, txv});
    chk("R4", "tx_data", tx_data_o, txv ? head : 32'h0);
    chk("R9", "dma_tx", {31'h0, dma_tx_req_o}, {31'h0, tsvc});
    chk("R9", "dma_rx", {31'h0, dma_rx_req_o}, {31'h0, rsvc});
    chk("R10", "irq", {31'h0, irq_o}, {31'h0, irq});
    chk("R2", "link/bclk", {30'h0, link_en_o, bclk_drive_o}, {30'h0, en, m_ctrl[2]});
    chk("R3", "msb", {31'h0, msb_just_o}, {31'h0, m_fmt[0]});
    @(posedge clk_i);
    if (rstb) begin
      q_tx.delete(); q_rx.delete(); m_ovr = 0; m_udr = 0;
    end else begin
      tx_pop  = act && !dpl && tr && txl > 0;
      udr_ev  = act && !dpl && tr && txl == 0;
      tx_push = s && w && a == 5 && (txl < 16 || tx_pop);
      rx_v    = lp ? tx_pop : rv;
      rx_d    = lp ? head : rdd;
      rx_in   = act && !drc && rx_v;
      rx_pop  = s && !w && a == 5 && rxl > 0;
      rx_push = rx_in && (rxl < 16 || rx_pop);
      ovr_ev  = rx_in && !rx_push;
      if (tx_pop) void'(q_tx.pop_front());
      if (tx_push) q_tx.push_back(d);
      if (rx_pop) void'(q_rx.pop_front());
      if (rx_push) q_rx.push_back(rx_d);
      m_ovr = ovr_ev || (m_ovr && !(s && w && a == 4 && d[6]));
      m_udr = udr_ev || (m_udr && !(s && w && a == 4 && d[5]));
    end
    if (s && w)
      case (a)
        0: m_ctrl = d & 32'hFF0D;
        1: m_fmt  = d & 32'h39;
        3: m_mask = d & 32'h78;
        default: ;
      endcase
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d, string tag = "R1");
    cyc(1, 1, a, d, 0, 0, 0, tag);
  endtask
  task automatic rd(logic [2:0] a, string tag);
    cyc(1, 0, a, 0, 0, 0, 0, tag);
  endtask
  task automatic idle(int n, string tag = "R1");
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (4) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    // R1 reset state and address map
    rd(2, "R1"); rd(0, "R1"); rd(5, "R1"); rd(6, "R1");
    // R2 control layout
    wr(0, 32'hFFFF_8404, "R2"); rd(0, "R2");
    // R10 mask
    wr(3, 32'hFFFF_FFFF, "R10"); rd(3, "R10");
    // R4 fill tx while link off, 17th dropped
    for (int i = 0; i < 17; i++) wr(5, 32'hA000_0000 + i, "R4");
    rd(2, "R13");
    wr(0, 32'h8405, "R2"); rd(2, "R13");
    // R14 push to full tx with concurrent pop
    cyc(1, 1, 5, 32'hA0A0_0077, 1, 0, 0, "R14"); rd(2, "R14");
    // R5 drain then underrun
    for (int i = 0; i < 20; i++) cyc(0, 0, 0, 0, 1, 0, 0, "R5");
    rd(2, "R5");
    // R8 clear with same-cycle event keeps flag; plain clear drops it
    cyc(1, 1, 4, 32'h20, 1, 0, 0, "R8"); rd(2, "R8");
    wr(4, 32'h20, "R8"); rd(2, "R8");
    // R6 fill rx and overrun
    for (int i = 0; i < 18; i++) cyc(0, 0, 0, 0, 0, 1, 32'hB000_0000 + i, "R6");
    rd(2, "R6");
    // R14 read from full rx with concurrent arrival
    cyc(1, 0, 5, 0, 0, 1, 32'hB0B0_0099, "R14"); rd(2, "R14");
    // R7 drain rx, empty read gives zero
    for (int i = 0; i < 18; i++) rd(5, "R7");
    rd(2, "R7");
    wr(4, 32'h60, "R8"); rd(2, "R8");
    // R10 partial mask
    wr(3, 32'h40, "R10"); idle(2, "R10");
    // R12 loopback
    wr(1, 32'h20, "R12"); rd(1, "R3");
    for (int i = 0; i < 3; i++) wr(5, 32'hC000_0000 + i, "R12");
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 1, 1, 32'hDEAD_BEEF, "R12");
    cyc(0, 0, 0, 0, 0, 1, 32'hDEAD_BEEF, "R12");
    for (int i = 0; i < 4; i++) rd(5, "R12");
    // R3 playback/capture disabled, msb select
    wr(1, 32'hFF19, "R3"); rd(1, "R3");
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 1, 1, 32'h1234_5678, "R3");
    rd(2, "R3");
    // R11 reset bit
    wr(1, 32'h0, "R3");
    wr(5, 32'hE000_0001, "R11"); wr(5, 32'hE000_0002, "R11");
    cyc(0, 0, 0, 0, 0, 1, 32'hE100_0000, "R11");
    wr(0, 32'h840D, "R11");
    cyc(1, 1, 5, 32'hE000_0003, 1, 1, 32'hE200_0000, "R11");
    rd(5, "R11"); rd(2, "R11");
    wr(0, 32'h8405, "R11"); rd(2, "R11"); rd(5, "R11");
    // R9 threshold edges
    wr(0, 32'h2005, "R9"); rd(2, "R9");
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 0, 1, 32'hF000_0000 + i, "R9");
    rd(2, "R9"); wr(5, 32'h1, "R9"); rd(2, "R9");
    wr(0, 32'h0, "R13"); rd(2, "R13");
    idle(2);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule